// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight edge-triggered interrupt request lines and merges them onto one interrupt output for a host processor. Each rising edge on a request line sets a pending bit. Each line can be masked on its own. A priority resolver compares the best unmasked pending request with the best level already in service, and it raises the interrupt output only when the new request outranks everything in service.

The processor answers with two acknowledge strobes. On the first strobe, the winning pending bit moves into the in-service set. On the second strobe, an 8-bit vector number is returned together with a one-cycle valid flag. If no eligible request is waiting when the first strobe arrives, the block returns the vector for level 7 as a spurious answer and records nothing as in service. Software uses a small write-only register port to set the vector base, the mask and the priority mode, and to issue non-specific end-of-interrupt commands. In rotating mode, each end-of-interrupt command makes the finished level the lowest priority.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Only a rising edge on `irq_in[i]` sets pending bit i. The edge is seen at one clock edge, and `int_out` is high after that edge. A line held high does not set the bit again after its request has been acknowledged.
- R2: Writing address 1 sets the mask, where bit i masks line i. A masked pending request never raises `int_out`. The request stays pending and raises `int_out` once it is unmasked.
- R3: In fixed mode (address 2 bit 0 = 0), line 0 has the highest priority and line 7 the lowest. With several requests pending, the acknowledge serves the lowest index first.
- R4: While a level is in service, `int_out` rises only for an unmasked pending level of strictly higher priority. A request at the same level or a lower level waits.
- R5: The first `ack` strobe moves the winning bit from pending to in-service. The second strobe makes `vec_valid` high for exactly the next cycle. The two strobes may have idle cycles between them.
- R6: The vector is {base[7:3], level[2:0]}. The base is written at address 0, and only its upper five bits are kept.
- R7: If no unmasked request outranks the in-service set at the first strobe, the vector carries level 7 and no in-service bit is set.
- R8: A write to address 3 (any data) clears the highest-priority in-service bit. It has no effect when the in-service set is empty.
- R9: In rotating mode (address 2 bit 0 = 1), the level cleared by an end-of-interrupt becomes the lowest priority, and the level after it (mod 8) becomes the highest.
- R10: After reset, `int_out` and `vec_valid` are 0, masks are clear, fixed mode is selected, the base is 0, and the pending and in-service sets are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines, edge-triggered |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 base, 1 mask, 2 mode, 3 end-of-interrupt |
| cfg_wdata | input | 8 | Register write data |
| ack | input | 1 | Acknowledge strobe, one cycle per pulse |
| int_out | output | 1 | Interrupt toward the processor |
| vec_out | output | 8 | Vector number |
| vec_valid | output | 1 | Vector valid, one cycle |

## Verification
The bench builds the block with its default of eight lines and 8-bit vectors. At that size every single level, every ordered pair of simultaneous requests and all 64 combinations of in-service level and new request can be swept. Rotating mode is exercised from all eight starting levels, each followed by the full eight-deep service order. The expected vectors are computed as base OR level, and the expected winners are computed with modular arithmetic.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef enum logic {ACK_IDLE, ACK_WAIT2} ack_state_e;
  localparam logic [1:0] CFG_BASE = 2'd0;
  localparam logic [1:0] CFG_MASK = 2'd1;
  localparam logic [1:0] CFG_MODE = 2'd2;
  localparam logic [1:0] CFG_EOI  = 2'd3;
endpackage

// File: rtl/irq_req_latch.sv
`timescale 1ns/1ps
module irq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q, irr_q, irr_d, rise;

  always_comb begin
    rise  = irq_in & ~prev_q;
    irr_d = (irr_q & ~clr_vec) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;

  // A newly set pending bit must come from an edge seen one cycle earlier
  assert_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_q & ~$past(irr_q) & ~$past(irq_in & ~prev_q)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low_lvl,
  output logic          any,
  output logic [LW-1:0] lvl,
  output logic [LW-1:0] rank
);
  always_comb begin
    logic [LW-1:0] idx;
    any  = 1'b0;
    lvl  = '0;
    rank = '0;
    idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = low_lvl + LW'(i + 1);
      if (vec[idx]) begin
        any  = 1'b1;
        rank = LW'(i);
        lvl  = idx;
      end
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
`timescale 1ns/1ps
module irq_ack_seq
  import irq_pkg::*;
#(
  parameter int LW    = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             grant_ok,
  input  logic [LW-1:0]    win_lvl,
  input  logic [VEC_W-LW-1:0] base,
  output logic             commit,
  output logic             spurious,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  localparam logic [LW-1:0] SPUR_LVL = '1;

  ack_state_e       st_q, st_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             val_q, val_d;

  always_comb begin
    st_d     = st_q;
    lvl_d    = lvl_q;
    vec_d    = vec_q;
    val_d    = 1'b0;
    commit   = 1'b0;
    spurious = 1'b0;
    if (ack) begin
      if (st_q == ACK_IDLE) begin
        commit   = grant_ok;
        spurious = !grant_ok;
        lvl_d    = grant_ok ? win_lvl : SPUR_LVL;
        st_d     = ACK_WAIT2;
      end else begin
        vec_d = {base, lvl_q};
        val_d = 1'b1;
        st_d  = ACK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACK_IDLE;
      lvl_q <= '0;
      vec_q <= '0;
      val_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
      vec_q <= vec_d;
      val_q <= val_d;
    end
  end

  assign vec_out   = vec_q;
  assign vec_valid = val_q;

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  assert_vec_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[VEC_W-1:LW] == $past(base)));
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             ack,
  output logic             int_out,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  localparam int LW     = $clog2(N_IRQ);
  localparam int BASE_W = VEC_W - LW;
  localparam logic [LW-1:0] FIX_LOW = LW'(N_IRQ - 1);

  logic [BASE_W-1:0] base_q, base_d;
  logic [N_IRQ-1:0]  mask_q, mask_d;
  logic              rot_q, rot_d;
  logic [LW-1:0]     low_q, low_d, eff_low;
  logic [N_IRQ-1:0]  isr_q, isr_d;

  logic [N_IRQ-1:0]  irr, pend, set_vec, eoi_clr;
  logic              p_any, s_any, grant_ok, commit, spurious, eoi;
  logic [LW-1:0]     p_lvl, p_rank, s_lvl, s_rank;

  irq_req_latch #(.N(N_IRQ)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_vec(set_vec), .irr(irr)
  );

  assign eff_low = rot_q ? low_q : FIX_LOW;
  assign pend    = irr & ~mask_q;

  irq_prio_pick #(.N(N_IRQ), .LW(LW)) u_pick_pend (
    .vec(pend), .low_lvl(eff_low), .any(p_any), .lvl(p_lvl), .rank(p_rank)
  );
  irq_prio_pick #(.N(N_IRQ), .LW(LW)) u_pick_isr (
    .vec(isr_q), .low_lvl(eff_low), .any(s_any), .lvl(s_lvl), .rank(s_rank)
  );

  assign grant_ok = p_any && (!s_any || (p_rank < s_rank));
  assign int_out  = grant_ok;

  irq_ack_seq #(.LW(LW), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack(ack), .grant_ok(grant_ok), .win_lvl(p_lvl),
    .base(base_q), .commit(commit), .spurious(spurious),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  always_comb begin
    eoi     = cfg_we && (cfg_addr == CFG_EOI);
    set_vec = commit ? (N_IRQ'(1) << p_lvl) : '0;
    eoi_clr = (eoi && s_any) ? (N_IRQ'(1) << s_lvl) : '0;
    isr_d   = (isr_q & ~eoi_clr) | set_vec;
    low_d   = (eoi && s_any && rot_q) ? s_lvl : low_q;
    base_d  = base_q;
    mask_d  = mask_q;
    rot_d   = rot_q;
    if (cfg_we) begin
      case (cfg_addr)
        CFG_BASE: base_d = cfg_wdata[7:8-BASE_W];
        CFG_MASK: mask_d = cfg_wdata[N_IRQ-1:0];
        CFG_MODE: rot_d  = cfg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      rot_q  <= 1'b0;
      low_q  <= FIX_LOW;
      isr_q  <= '0;
    end else begin
      base_q <= base_d;
      mask_q <= mask_d;
      rot_q  <= rot_d;
      low_q  <= low_d;
      isr_q  <= isr_d;
    end
  end

  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask_q) != '0));
  assert_isr_one_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1));
  assert_spur_no_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |=> ((isr_q & ~$past(isr_q)) == '0));
  assert_eoi_clears_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && s_any && !commit) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       ack = 1'b0;
  logic       int_out, vec_valid;
  logic [7:0] vec_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ack(ack), .int_out(int_out), .vec_out(vec_out),
    .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic eoi();
    cfg(2'd3, 8'h00);
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    irq = v;
    step();
    irq = '0;
  endtask

  // two strobes with a gap; returns vector and int_out seen after the first strobe
  task automatic do_ack(output logic [7:0] v, output logic int_mid);
    ack = 1'b1; step(); ack = 1'b0;
    int_mid = int_out;
    step();
    ack = 1'b1; step(); ack = 1'b0;
    chk("R5 valid after second strobe", {7'd0, vec_valid}, 8'd1);
    v = vec_out;
    step();
    chk("R5 valid lasts one cycle", {7'd0, vec_valid}, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       m;
    logic [7:0] bases [4] = '{8'h08, 8'h20, 8'hF8, 8'h77};
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk("R10 int_out", {7'd0, int_out}, 8'd0);
    chk("R10 vec_valid", {7'd0, vec_valid}, 8'd0);
    do_ack(v, m);
    chk("R10 base zero, nothing pending", v, 8'h07);

    // R1 R5 R6 single levels over several bases
    foreach (bases[b]) begin
      cfg(2'd0, bases[b]);
      for (int l = 0; l < 8; l++) begin
        pulse_irq(8'(1 << l));
        chk("R1 edge raises int_out", {7'd0, int_out}, 8'd1);
        do_ack(v, m);
        chk("R5 first strobe drops int_out", {7'd0, m}, 8'd0);
        chk("R6 vector", v, (bases[b] & 8'hF8) | 8'(l));
        eoi();
        chk("R8 idle after eoi", {7'd0, int_out}, 8'd0);
      end
    end
    cfg(2'd0, 8'h40);

    // R1 held line does not re-latch
    irq = 8'h08; step();
    do_ack(v, m);
    chk("R1 held line vector", v, 8'h43);
    eoi();
    step();
    chk("R1 held line no relatch", {7'd0, int_out}, 8'd0);
    irq = '0; step();

    // R2 mask
    for (int l = 0; l < 8; l++) begin
      cfg(2'd1, 8'(1 << l));
      pulse_irq(8'(1 << l));
      chk("R2 masked no int", {7'd0, int_out}, 8'd0);
      cfg(2'd1, 8'h00);
      chk("R2 unmask releases", {7'd0, int_out}, 8'd1);
      do_ack(v, m);
      chk("R2 vector after unmask", v, 8'h40 | 8'(l));
      eoi();
    end

    // R3 fixed priority over all pairs
    for (int a = 0; a < 8; a++) begin
      for (int c = a + 1; c < 8; c++) begin
        pulse_irq(8'((1 << a) | (1 << c)));
        do_ack(v, m);
        chk("R3 higher first", v, 8'h40 | 8'(a));
        eoi();
        do_ack(v, m);
        chk("R3 lower second", v, 8'h40 | 8'(c));
        eoi();
      end
    end

    // R4 preemption gated by in-service level
    for (int l = 0; l < 8; l++) begin
      for (int r = 0; r < 8; r++) begin
        pulse_irq(8'(1 << l));
        do_ack(v, m);
        pulse_irq(8'(1 << r));
        chk("R4 preempt only if higher", {7'd0, int_out}, (r < l) ? 8'd1 : 8'd0);
        if (r < l) begin
          do_ack(v, m);
          chk("R4 preempting vector", v, 8'h40 | 8'(r));
          eoi();
          chk("R8 eoi cleared top, lower still in service", {7'd0, int_out}, 8'd0);
          eoi();
        end else begin
          eoi();
          chk("R8 eoi frees waiting request", {7'd0, int_out}, 8'd1);
          do_ack(v, m);
          chk("R4 waiting vector", v, 8'h40 | 8'(r));
          eoi();
        end
        chk("R8 all cleared", {7'd0, int_out}, 8'd0);
      end
    end

    // R7 spurious responses
    do_ack(v, m);
    chk("R7 empty ack gives level 7", v, 8'h47);
    pulse_irq(8'h80);
    chk("R7 level 7 not left in service", {7'd0, int_out}, 8'd1);
    do_ack(v, m);
    chk("R7 real level 7", v, 8'h47);
    eoi();
    cfg(2'd1, 8'hFF);
    pulse_irq(8'h01);
    do_ack(v, m);
    chk("R7 masked pending is spurious", v, 8'h47);
    cfg(2'd1, 8'h00);
    chk("R7 request kept", {7'd0, int_out}, 8'd1);
    do_ack(v, m);
    chk("R7 kept request served", v, 8'h40);
    eoi();

    // R9 rotating priority from every starting level
    cfg(2'd2, 8'h01);
    for (int l = 0; l < 8; l++) begin
      pulse_irq(8'(1 << l));
      do_ack(v, m);
      chk("R9 setup vector", v, 8'h40 | 8'(l));
      eoi();
      pulse_irq(8'hFF);
      for (int k = 1; k <= 8; k++) begin
        do_ack(v, m);
        chk("R9 rotated order", v, 8'h40 | 8'((l + k) % 8));
        eoi();
      end
      chk("R9 drained", {7'd0, int_out}, 8'd0);
    end
    cfg(2'd2, 8'h00);
    pulse_irq(8'h81);
    do_ack(v, m);
    chk("R3 fixed order restored", v, 8'h40);
    eoi();
    do_ack(v, m);
    chk("R3 fixed order restored low", v, 8'h47);
    eoi();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule